// File: doc/BRIEF.md
# Vector Float-to-Integer Converter

This block turns every lane of a floating-point vector into a signed integer in one registered stage. Each lane is a 32-bit slot. A single three-bit type-pair code tells the block how to read the source and what integer width to produce. Half precision and brain-float inputs occupy the low 16 bits of a slot. Single precision fills the whole slot. A 16-bit result is sign-extended into its 32-bit output slot.

The rounding rule is picked per vector from six choices: ties-to-even, away from zero, floor, ceiling, toward zero and round-to-odd. A saturation flag decides what happens when a value does not fit. With the flag set, the result clamps to the range limits. With the flag clear, the result wraps.

A typical use is quantisation. Another is floor division: the quotient is first floored to an integer-valued float, and this block then converts it exactly with toward-zero rounding.

Top module: `f2i_vec_conv`

## Requirements
- R1: Type-pair codes are 0 = half to 16-bit, 1 = half to 32-bit, 2 = single to 16-bit, 3 = single to 32-bit and 4 = brain-float to 32-bit. For codes 5, 6 and 7 the accepted vector produces all-zero data and `out_err` high for that one output cycle. `out_err` is low for every legal vector.
- R2: `out_valid` equals `in_valid` from one clock earlier. After a synchronous active-low reset, `out_valid`, `out_err` and `out_data` are all zero.
- R3: A lane occupies bits [32*i+31:32*i]. Half and brain-float sources are read from bits [15:0] of the lane, and bits [31:16] have no effect. A 16-bit result is sign-extended to 32 bits.
- R4: Rounding codes are 0 = ties-to-even, 1 = away from zero, 2 = floor, 3 = ceiling and 4 = toward zero. Codes 6 and 7 behave as code 0.
- R5: Rounding code 5 (round-to-odd) yields the odd neighbouring integer whenever the input has a nonzero fraction. An exact input is left unchanged.
- R6: With `in_sat` = 1, a rounded value above the destination maximum gives INT_MAX and one below the minimum gives INT_MIN. These are 32767 / -32768 for 16-bit results and 2147483647 / -2147483648 for 32-bit results.
- R7: A NaN input gives zero whatever the saturation setting. An infinite input clamps to INT_MAX or INT_MIN when saturating and gives zero otherwise.
- R8: With `in_sat` = 0, a finite out-of-range value keeps the low destination-width bits of the two's-complement rounded value.
- R9: An integer-valued input that is within range converts exactly under every rounding code.
- R10: Lanes are converted independently. A zero bit pattern in a lane gives zero in that lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Source vector is present |
| in_data | input | 32*LANES | Source lanes |
| in_pair | input | 3 | Type-pair code |
| in_round | input | 3 | Rounding code |
| in_sat | input | 1 | Saturation enable |
| out_valid | output | 1 | Result vector is present |
| out_data | output | 32*LANES | Integer result lanes |
| out_err | output | 1 | Illegal type-pair flag |

## Verification
On every cycle, the assertions check the one-cycle valid timing. They check that an illegal pair gives zero data with the error flag, and that the error flag never appears without valid. They also check that 16-bit results are always correctly sign-extended and that a zero lane gives a zero result. Rounding correctness under each mode, the clamp and wrap values, and NaN/infinity handling can only be shown by the bench's scenarios. These compare every lane against an arithmetic reference: exhaustive sweeps over all 16-bit source encodings and a long pseudo-random single-precision sweep.

// File: rtl/f2i_vec_conv.sv
module f2i_vec_conv #(
  parameter int LANES = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [32*LANES-1:0]   in_data,
  input  logic [2:0]            in_pair,
  input  logic [2:0]            in_round,
  input  logic                  in_sat,
  output logic                  out_valid,
  output logic [32*LANES-1:0]   out_data,
  output logic                  out_err
);

  localparam int DW = 32 * LANES;

  function automatic logic [31:0] cvt_lane(input logic [31:0] x, input logic [2:0] pair,
                                           input logic [2:0] rm, input logic sat);
    logic        s, nan, inf, narrow, lsb, half, sticky, inexact, inc, huge, ovf;
    logic [23:0] m;
    logic [48:0] ext;
    logic [63:0] mag, sv, lim;
    int          e;
    s = 1'b0; nan = 1'b0; inf = 1'b0; m = '0; e = 0;
    narrow = (pair == 3'd0) || (pair == 3'd2);
    case (pair)
      3'd0, 3'd1: begin
        s = x[15];
        nan = (x[14:10] == 5'h1f) && (|x[9:0]);
        inf = (x[14:10] == 5'h1f) && !(|x[9:0]);
        e = (x[14:10] == 5'd0) ? -14 : int'(x[14:10]) - 15;
        m = {|x[14:10], x[9:0], 13'd0};
      end
      3'd2, 3'd3: begin
        s = x[31];
        nan = (x[30:23] == 8'hff) && (|x[22:0]);
        inf = (x[30:23] == 8'hff) && !(|x[22:0]);
        e = (x[30:23] == 8'd0) ? -126 : int'(x[30:23]) - 127;
        m = {|x[30:23], x[22:0]};
      end
      3'd4: begin
        s = x[15];
        nan = (x[14:7] == 8'hff) && (|x[6:0]);
        inf = (x[14:7] == 8'hff) && !(|x[6:0]);
        e = (x[14:7] == 8'd0) ? -126 : int'(x[14:7]) - 127;
        m = {|x[14:7], x[6:0], 16'd0};
      end
      default: ;
    endcase

    half = 1'b0; sticky = 1'b0; huge = 1'b0; mag = '0; ext = '0;
    if (e >= 24) begin
      mag  = {40'd0, m} << (e - 23);
      huge = (e >= 40);
    end else if (e >= -2) begin
      ext    = {m, 25'd0} >> (23 - e);
      mag    = {40'd0, ext[48:25]};
      half   = ext[24];
      sticky = |ext[23:0];
    end else begin
      sticky = |m;
    end

    lsb     = mag[0];
    inexact = half | sticky;
    case (rm)
      3'd1:    inc = inexact;
      3'd2:    inc = s & inexact;
      3'd3:    inc = ~s & inexact;
      3'd4:    inc = 1'b0;
      3'd5:    inc = inexact & ~lsb;
      default: inc = half & (sticky | lsb);
    endcase
    mag = mag + {63'd0, inc};
    sv  = s ? (~mag + 64'd1) : mag;
    lim = narrow ? 64'd32767 : 64'h7fff_ffff;
    ovf = huge || (mag > lim + {63'd0, s});

    if (nan)
      return 32'd0;
    if (inf && !sat)
      return 32'd0;
    if (inf || (sat && ovf)) begin
      if (s) return narrow ? 32'hffff_8000 : 32'h8000_0000;
      else   return narrow ? 32'h0000_7fff : 32'h7fff_ffff;
    end
    return narrow ? {{16{sv[15]}}, sv[15:0]} : sv[31:0];
  endfunction

  logic          illegal;
  logic [DW-1:0] conv;

  assign illegal = (in_pair > 3'd4);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign conv[32*l +: 32] = illegal ? 32'd0 : cvt_lane(in_data[32*l +: 32], in_pair, in_round, in_sat);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_err   <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      out_err   <= in_valid & illegal;
      if (in_valid) out_data <= conv;
    end
  end

endmodule

// File: rtl/f2i_vec_chk.sv
module f2i_vec_chk #(
  parameter int LANES = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [32*LANES-1:0] in_data,
  input logic [2:0]          in_pair,
  input logic                out_valid,
  input logic [32*LANES-1:0] out_data,
  input logic                out_err
);

  p_valid_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (out_valid == $past(in_valid)));

  p_err_needs_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> out_valid);

  p_illegal_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(in_valid) && ($past(in_pair) > 3'd4)) |-> (out_err && out_data == '0));

  p_legal_no_err_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(in_valid) && ($past(in_pair) <= 3'd4)) |-> !out_err);

  for (genvar l = 0; l < LANES; l++) begin : g_lchk
    p_narrow_sext_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(in_valid) && ($past(in_pair) == 3'd0 || $past(in_pair) == 3'd2))
      |-> (out_data[32*l+15 +: 17] == 17'd0 || out_data[32*l+15 +: 17] == 17'h1ffff));

    p_zero_lane_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(in_valid) && ($past(in_data[32*l +: 32]) == 32'd0))
      |-> (out_data[32*l +: 32] == 32'd0));
  end

endmodule

bind f2i_vec_conv f2i_vec_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_pair(in_pair),
  .out_valid(out_valid), .out_data(out_data), .out_err(out_err)
);

// File: tb/tb_f2i_vec_conv.sv
`timescale 1ns/1ps
module tb_f2i_vec_conv;
  localparam int LANES = 8;
  localparam int DW = 32 * LANES;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic [2:0]    in_pair = 3'd0;
  logic [2:0]    in_round = 3'd0;
  logic          in_sat = 1'b0;
  logic          out_valid;
  logic [DW-1:0] out_data;
  logic          out_err;

  f2i_vec_conv #(.LANES(LANES)) dut (.*);

  always #2.5 clk = ~clk;

  int n_checks = 0;
  int n_fail = 0;
  logic [31:0] seed = 32'h1234_5678;

  logic          pend_v = 1'b0;
  logic          pend_err = 1'b0;
  logic [DW-1:0] pend_data = '0;
  string         pend_tag = "R2";

  function automatic logic [31:0] nxt(input logic [31:0] r);
    logic [31:0] t;
    t = r ^ (r << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  function automatic logic [31:0] ref_cvt(input logic [31:0] x, input int pair, input int rm, input bit sat);
    real a, fl, fr, r;
    bit s, nan, inf, up, odd;
    int W, ef;
    longint q;
    logic [63:0] qb;
    logic [31:0] mx, mn;
    s = 0; nan = 0; inf = 0; a = 0.0;
    if (pair <= 1) begin
      s = x[15]; ef = int'(x[14:10]);
      if (ef == 31) begin nan = (x[9:0] != 0); inf = (x[9:0] == 0); end
      else if (ef == 0) a = real'(x[9:0]) / 1024.0 * (2.0 ** -14);
      else a = (1.0 + real'(x[9:0]) / 1024.0) * (2.0 ** (ef - 15));
    end else if (pair <= 3) begin
      s = x[31]; ef = int'(x[30:23]);
      if (ef == 255) begin nan = (x[22:0] != 0); inf = (x[22:0] == 0); end
      else if (ef == 0) a = real'(x[22:0]) / 8388608.0 * (2.0 ** -126);
      else a = (1.0 + real'(x[22:0]) / 8388608.0) * (2.0 ** (ef - 127));
    end else begin
      s = x[15]; ef = int'(x[14:7]);
      if (ef == 255) begin nan = (x[6:0] != 0); inf = (x[6:0] == 0); end
      else if (ef == 0) a = real'(x[6:0]) / 128.0 * (2.0 ** -126);
      else a = (1.0 + real'(x[6:0]) / 128.0) * (2.0 ** (ef - 127));
    end
    W  = (pair == 0 || pair == 2) ? 16 : 32;
    mx = (W == 16) ? 32'h0000_7fff : 32'h7fff_ffff;
    mn = (W == 16) ? 32'hffff_8000 : 32'h8000_0000;
    if (nan) return 32'd0;
    if (inf) return sat ? (s ? mn : mx) : 32'd0;
    fl = $floor(a);
    fr = a - fl;
    odd = (fl < 4.0e18) ? ((longint'(fl) % 2) != 0) : 1'b0;
    case (rm)
      1: up = (fr > 0.0);
      2: up = s && (fr > 0.0);
      3: up = !s && (fr > 0.0);
      4: up = 1'b0;
      5: up = (fr > 0.0) && !odd;
      default: up = (fr > 0.5) || (fr == 0.5 && odd);
    endcase
    r = up ? fl + 1.0 : fl;
    if (sat) begin
      if (!s && r > (2.0 ** (W - 1)) - 1.0) return mx;
      if (s && r > (2.0 ** (W - 1))) return mn;
    end
    q = (r >= 4.0e18) ? 64'sd0 : longint'(r);
    if (s) q = -q;
    qb = q;
    return (W == 16) ? {{16{qb[15]}}, qb[15:0]} : qb[31:0];
  endfunction

  function automatic logic [31:0] int_to_f32(input int k);
    logic [63:0] d;
    if (k == 0) return 32'd0;
    d = $realtobits(real'(k));
    return {d[63], d[62:52] - 11'd896 == 11'd0 ? 8'd0 : 8'(d[62:52] - 11'd896), d[51:29]};
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit v, input int pair, input int rm, input bit sat,
                      input logic [DW-1:0] d, input string tag);
    @(negedge clk);
    if (pend_v) begin
      check(out_valid == 1'b1, "R2", "out_valid", {31'd0, out_valid}, 32'd1);
      check(out_err == pend_err, "R1", "out_err", {31'd0, out_err}, {31'd0, pend_err});
      for (int l = 0; l < LANES; l++)
        check(out_data[32*l +: 32] == pend_data[32*l +: 32], pend_tag, $sformatf("lane %0d", l),
              out_data[32*l +: 32], pend_data[32*l +: 32]);
    end else begin
      check(out_valid == 1'b0, "R2", "out_valid idle", {31'd0, out_valid}, 32'd0);
      check(out_err == 1'b0, "R1", "out_err idle", {31'd0, out_err}, 32'd0);
    end
    pend_v   = v;
    pend_err = v && (pair > 4);
    pend_tag = tag;
    for (int l = 0; l < LANES; l++)
      pend_data[32*l +: 32] = (pair > 4) ? 32'd0 : ref_cvt(d[32*l +: 32], pair, rm, sat);
    in_valid = v;
    in_pair  = 3'(pair);
    in_round = 3'(rm);
    in_sat   = sat;
    in_data  = d;
  endtask

  initial begin
    #(5.0 * 190000);
    n_checks++;
    n_fail++;
    $display("FAIL R2 watchdog: actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R2", "reset out_valid", {31'd0, out_valid}, 32'd0);
    check(out_err == 1'b0, "R2", "reset out_err", {31'd0, out_err}, 32'd0);
    check(out_data == '0, "R2", "reset out_data", out_data[31:0], 32'd0);
    rst_n = 1'b1;

    // R4 R6: every half-precision code, every rounding mode, saturating to 32-bit; junk upper bits (R3)
    for (int rm = 0; rm < 6; rm++)
      for (int v = 0; v < 65536; v += LANES) begin
        for (int l = 0; l < LANES; l++) begin
          seed = nxt(seed);
          d[32*l +: 32] = {seed[31:16], 16'(v + l)};
        end
        step(1, 1, rm, 1, d, (rm == 5) ? "R5" : "R4");
      end

    // R8 R6 R7: half to 16-bit, all rounding codes incl. 6 and 7, saturation alternating
    for (int v = 0; v < 65536; v += LANES) begin
      for (int l = 0; l < LANES; l++) begin
        seed = nxt(seed);
        d[32*l +: 32] = {seed[15:0], 16'(v + l)};
      end
      step(1, 0, (v / LANES) % 8, ((v / LANES / 8) % 2) == 1, d, "R8");
    end

    // R7 R3: every brain-float code to 32-bit
    for (int v = 0; v < 65536; v += LANES) begin
      for (int l = 0; l < LANES; l++) begin
        seed = nxt(seed);
        d[32*l +: 32] = {seed[31:16], 16'(v + l)};
      end
      step(1, 4, (v / LANES) % 6, ((v / LANES) % 3) != 0, d, "R7");
    end

    // R6 R8 R10: single precision around the integer range, both widths
    for (int n = 0; n < 16000; n++) begin
      for (int l = 0; l < LANES; l++) begin
        logic [7:0] ex;
        seed = nxt(seed);
        ex = 8'(100 + (seed[31:8] % 60));
        if (seed[7:0] == 8'd0) ex = 8'hff;
        if (seed[7:0] == 8'd1) ex = 8'd0;
        d[32*l +: 32] = {seed[30], ex, seed[22:0] ^ {seed[7:0], 15'd0}};
      end
      seed = nxt(seed);
      step(1, (n % 2 == 0) ? 3 : 2, int'(seed[2:0]), seed[3], d, (n % 2 == 0) ? "R6" : "R10");
    end

    // R9: integer-valued single precision converts exactly under every code
    for (int rm = 0; rm < 8; rm++)
      for (int k = -40000; k < 40000; k += 997 * LANES) begin
        for (int l = 0; l < LANES; l++) d[32*l +: 32] = int_to_f32(k + 997 * l);
        step(1, 3, rm, rm % 2 == 0, d, "R9");
      end

    // R1: illegal pairs, and idle cycles
    for (int p = 5; p < 8; p++) begin
      for (int l = 0; l < LANES; l++) d[32*l +: 32] = 32'h4049_0fdb;
      step(1, p, 0, 1, d, "R1");
      step(0, 3, 0, 1, d, "R2");
    end
    step(0, 0, 0, 0, '0, "R2");
    step(0, 0, 0, 0, '0, "R2");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule